// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Aggregator

This block watches one group of 32 already-synchronized pin levels and turns chosen transitions into sticky interrupt status. Each pin can be armed for rising transitions, falling transitions, both, or neither. An armed transition sets that pin's status bit, and software clears the bit by writing a one to it. Pin state is the only input that matters. A pin that the surrounding logic drives as an output is detected in the same way as any other pin.

The 32 status bits form two banks of 16. The lower half feeds bank 0 and the upper half feeds bank 1. Each bank has one shared interrupt line: it is the OR of the bank's status bits, gated by that bank's bit in a bank-enable register. The first eight pins also each drive a direct interrupt output. That output follows the pin's status bit whether or not the bank enable is set.

Configuration uses a single-cycle write bus and a combinational read-back port. The rising and falling arm masks are each written through a pair of aliases: one alias sets bits and the other clears them.

Top module: `gpio_edge_irq_agg`

## Requirements
- R1: After reset, the arm masks, the bank enables and every status bit are zero, and all interrupt outputs are low.
- R2: A write to 0x10 sets each rising-arm bit whose data bit is 1, and a write to 0x18 does the same for the falling-arm mask. Data bits that are 0 leave the mask unchanged. Reads at 0x10 or 0x14 return the rising mask, and reads at 0x18 or 0x1C return the falling mask.
- R3: A write to 0x14 (rising) or 0x1C (falling) clears each arm bit whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R4: A pin sampled low on one clock and high on the next, with its rising-arm bit set, has its status bit read as 1 at 0x20 from the clock after the high sample.
- R5: A high-to-low change sets status only when the falling-arm bit is set. With both arm bits set, both directions set status. With neither arm bit set, no change on the pin sets status.
- R6: A write to 0x20 clears each status bit whose data bit is 1. Data bits that are 0 leave status unchanged.
- R7: When an armed transition and a write-1 clear hit the same status bit in the same clock, the bit ends up set.
- R8: bank_irq[0] is high exactly when bank-enable bit 0 (address 0x08, bit 0) is 1 and any of status bits 15:0 is 1. bank_irq[1] is high exactly when bank-enable bit 1 is 1 and any of status bits 31:16 is 1. Reads at 0x08 return the bank enables.
- R9: direct_irq[i], for i from 0 to 7, equals status bit i regardless of the bank enables.
- R10: Reads at any address not named above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 8 | Byte address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| bank_irq | output | 2 | Gated per-bank interrupt lines |
| direct_irq | output | 8 | Direct interrupt lines for pins 0 to 7 |

## Verification
Two functions can land on one status bit in the same clock: setting it from an armed transition and clearing it through a write-1 to the status address. The bench sets a bit, then in one cycle drives an armed rising change on that pin and writes the clear. It expects the bit to survive, and expects it to clear on a later write that has no transition alongside it. A random phase then mixes pin toggles with writes to every alias, so the same collisions also arise unprompted. These are judged against a behavioural model compared on every clock.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_BANK_EN  = 8'h08;
  localparam logic [ADDR_W-1:0] A_RISE_SET = 8'h10;
  localparam logic [ADDR_W-1:0] A_RISE_CLR = 8'h14;
  localparam logic [ADDR_W-1:0] A_FALL_SET = 8'h18;
  localparam logic [ADDR_W-1:0] A_FALL_CLR = 8'h1C;
  localparam logic [ADDR_W-1:0] A_STATUS   = 8'h20;
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_lvl,
  input  logic [PINS-1:0] rise_en,
  input  logic [PINS-1:0] fall_en,
  output logic [PINS-1:0] hit
);
  logic [PINS-1:0] prev_q;

  // Each pin keeps its level from the previous clock; a difference is a transition.
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      hit[i] = (pin_lvl[i] & ~prev_q[i] & rise_en[i])
             | (~pin_lvl[i] & prev_q[i] & fall_en[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_lvl;
  end
endmodule

// File: rtl/gpio_w1sc_reg.sv
module gpio_w1sc_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         upd;

  always_comb begin
    upd = set_stb | clr_stb;
    q_d = q;
    if (set_stb) q_d = q | wdata;
    if (clr_stb) q_d = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_d;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int PINS      = 32,
  parameter int BANK_PINS = 16,
  localparam int NBANK    = PINS / BANK_PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  hit,
  input  logic             clr_stb,
  input  logic [PINS-1:0]  wdata,
  output logic [PINS-1:0]  status_q,
  output logic [NBANK-1:0] bank_any
);
  logic [PINS-1:0] clr_mask;
  logic [PINS-1:0] status_d;

  // A new hit outranks a clear of the same bit.
  always_comb begin
    clr_mask = clr_stb ? wdata : '0;
    status_d = (status_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_any[b] = |status_q[b*BANK_PINS +: BANK_PINS];
  end
endmodule

// File: rtl/gpio_edge_irq_agg.sv
module gpio_edge_irq_agg
  import gpio_edge_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int BANK_PINS   = 16,
  parameter int DIRECT_PINS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PINS-1:0]             pin_lvl,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [PINS-1:0]             bus_wdata,
  output logic [PINS-1:0]             bus_rdata,
  output logic [PINS/BANK_PINS-1:0]   bank_irq,
  output logic [DIRECT_PINS-1:0]      direct_irq
);
  localparam int NBANK = PINS / BANK_PINS;

  logic             wr_rise_set, wr_rise_clr, wr_fall_set, wr_fall_clr;
  logic             wr_status, wr_bank;
  logic [PINS-1:0]  rise_en_q, fall_en_q, hit_vec, status_q;
  logic [NBANK-1:0] bank_any, bank_en_q, bank_en_d;

  always_comb begin
    wr_rise_set = bus_wr && (bus_addr == A_RISE_SET);
    wr_rise_clr = bus_wr && (bus_addr == A_RISE_CLR);
    wr_fall_set = bus_wr && (bus_addr == A_FALL_SET);
    wr_fall_clr = bus_wr && (bus_addr == A_FALL_CLR);
    wr_status   = bus_wr && (bus_addr == A_STATUS);
    wr_bank     = bus_wr && (bus_addr == A_BANK_EN);
  end

  gpio_w1sc_reg #(.W(PINS)) u_rise (
    .clk(clk), .rst_n(rst_n), .set_stb(wr_rise_set), .clr_stb(wr_rise_clr),
    .wdata(bus_wdata), .q(rise_en_q));

  gpio_w1sc_reg #(.W(PINS)) u_fall (
    .clk(clk), .rst_n(rst_n), .set_stb(wr_fall_set), .clr_stb(wr_fall_clr),
    .wdata(bus_wdata), .q(fall_en_q));

  gpio_edge_detect #(.PINS(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .rise_en(rise_en_q),
    .fall_en(fall_en_q), .hit(hit_vec));

  gpio_irq_status #(.PINS(PINS), .BANK_PINS(BANK_PINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .hit(hit_vec), .clr_stb(wr_status),
    .wdata(bus_wdata), .status_q(status_q), .bank_any(bank_any));

  always_comb begin
    bank_en_d = wr_bank ? bus_wdata[NBANK-1:0] : bank_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_en_q <= '0;
    else        bank_en_q <= bank_en_d;
  end

  always_comb begin
    bank_irq   = bank_any & bank_en_q;
    direct_irq = status_q[DIRECT_PINS-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_BANK_EN:              bus_rdata[NBANK-1:0] = bank_en_q;
      A_RISE_SET, A_RISE_CLR: bus_rdata = rise_en_q;
      A_FALL_SET, A_FALL_CLR: bus_rdata = fall_en_q;
      A_STATUS:               bus_rdata = status_q;
      default:                bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int BANK_PINS   = 16,
  parameter int DIRECT_PINS = 8,
  localparam int NBANK      = PINS / BANK_PINS
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [PINS-1:0]        bus_wdata,
  input logic [PINS-1:0]        hit,
  input logic [PINS-1:0]        status,
  input logic [PINS-1:0]        rise_en,
  input logic [PINS-1:0]        fall_en,
  input logic [NBANK-1:0]       bank_en,
  input logic [NBANK-1:0]       bank_irq,
  input logic [DIRECT_PINS-1:0] direct_irq
);
  // R2
  rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_RISE_SET) |=> ((rise_en & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  rise_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_RISE_CLR) |=> ((rise_en & $past(bus_wdata)) == '0));

  // R3
  fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FALL_CLR) |=> ((fall_en & $past(bus_wdata)) == '0));

  // R4
  hit_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status & $past(hit)) == $past(hit)));

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(hit)) == '0));

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STATUS && |(bus_wdata & ~hit))
      |=> ((status & $past(bus_wdata & ~hit)) == '0));

  // R7
  collide_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STATUS && |(bus_wdata & hit))
      |=> ((status & $past(bus_wdata & hit)) == $past(bus_wdata & hit)));

  // R9
  direct_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((direct_irq & ~$past(direct_irq) & ~$past(hit[DIRECT_PINS-1:0])) == '0));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank_chk
    // R8
    bank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bank_en[b]) |-> !bank_irq[b]);
    // R8
    bank_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_en[b] && |status[b*BANK_PINS +: BANK_PINS]) |-> bank_irq[b]);
  end
endmodule

bind gpio_edge_irq_agg gpio_edge_irq_chk #(
  .PINS(PINS), .BANK_PINS(BANK_PINS), .DIRECT_PINS(DIRECT_PINS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .hit(hit_vec), .status(status_q),
  .rise_en(rise_en_q), .fall_en(fall_en_q), .bank_en(bank_en_q),
  .bank_irq(bank_irq), .direct_irq(direct_irq)
);

// File: tb/gpio_edge_irq_agg_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_lvl = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  bank_irq;
  logic [7:0]  direct_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_edge_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bank_irq(bank_irq), .direct_irq(direct_irq));

  // Behavioural reference state
  bit m_rise [32];
  bit m_fall [32];
  bit m_stat [32];
  bit m_prev [32];
  bit m_ben  [2];

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        m_rise[i] = 0; m_fall[i] = 0; m_stat[i] = 0; m_prev[i] = 0;
      end
      m_ben[0] = 0; m_ben[1] = 0;
    end else begin
      bit ev [32];
      for (int i = 0; i < 32; i++) begin
        ev[i] = (pin_lvl[i] && !m_prev[i] && m_rise[i]) ||
                (!pin_lvl[i] && m_prev[i] && m_fall[i]);
      end
      for (int i = 0; i < 32; i++) begin
        if (bus_wr && bus_addr == 8'h20 && bus_wdata[i]) m_stat[i] = 0;
        if (ev[i]) m_stat[i] = 1;
        if (bus_wr && bus_addr == 8'h10 && bus_wdata[i]) m_rise[i] = 1;
        if (bus_wr && bus_addr == 8'h14 && bus_wdata[i]) m_rise[i] = 0;
        if (bus_wr && bus_addr == 8'h18 && bus_wdata[i]) m_fall[i] = 1;
        if (bus_wr && bus_addr == 8'h1C && bus_wdata[i]) m_fall[i] = 0;
        m_prev[i] = pin_lvl[i];
      end
      if (bus_wr && bus_addr == 8'h08) begin
        m_ben[0] = bus_wdata[0]; m_ben[1] = bus_wdata[1];
      end
    end
  end

  // Every-clock comparison, away from the edge
  always @(posedge clk) begin
    #1;
    begin
      logic [1:0]  e_bank;
      logic [7:0]  e_dir;
      logic [31:0] e_rd;
      string       tag;
      e_bank = '0;
      for (int b = 0; b < 2; b++) begin
        bit any;
        any = 0;
        for (int i = 0; i < 16; i++) if (m_stat[b*16+i]) any = 1;
        e_bank[b] = any && m_ben[b];
      end
      for (int i = 0; i < 8; i++) e_dir[i] = m_stat[i];
      e_rd = '0;
      tag = "R10";
      case (bus_addr)
        8'h08: begin e_rd[0] = m_ben[0]; e_rd[1] = m_ben[1]; tag = "R8"; end
        8'h10, 8'h14: begin for (int i = 0; i < 32; i++) e_rd[i] = m_rise[i]; tag = "R2"; end
        8'h18, 8'h1C: begin for (int i = 0; i < 32; i++) e_rd[i] = m_fall[i]; tag = "R2"; end
        8'h20: begin for (int i = 0; i < 32; i++) e_rd[i] = m_stat[i]; tag = "R4"; end
        default: ;
      endcase
      check("R8", "bank_irq", {30'd0, bank_irq}, {30'd0, e_bank});
      check("R9", "direct_irq", {24'd0, direct_irq}, {24'd0, e_dir});
      check(tag, "bus_rdata", bus_rdata, e_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic pins(input logic [31:0] p, input int n);
    @(negedge clk);
    pin_lvl = p;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h20, v); check("R1", "status after reset", v, 32'h0);
    rd(8'h10, v); check("R1", "rise mask after reset", v, 32'h0);
    check("R1", "irq outputs after reset", {22'd0, bank_irq, direct_irq}, 32'h0);
    // R2 set aliases, zero data has no effect
    wr(8'h10, 32'h0000_0003);
    wr(8'h10, 32'h0);
    rd(8'h10, v); check("R2", "rise mask set", v, 32'h0000_0003);
    wr(8'h18, 32'h0001_0002);
    rd(8'h1C, v); check("R2", "fall mask set", v, 32'h0001_0002);
    // R3 clear aliases
    wr(8'h14, 32'h0000_0001);
    wr(8'h14, 32'h0);
    rd(8'h14, v); check("R3", "rise mask clear", v, 32'h0000_0002);
    // R10 unmapped read
    rd(8'h04, v); check("R10", "unmapped read", v, 32'h0);
    wr(8'h08, 32'h3);
    // R5 pin 0 armed for neither edge
    pins(32'h0000_0001, 2);
    rd(8'h20, v); check("R5", "unarmed pin sets nothing", v, 32'h0);
    // R4 rising edge on pin 1
    pins(32'h0000_0003, 2);
    rd(8'h20, v); check("R4", "rise sets status", v, 32'h0000_0002);
    check("R8", "bank0 line", {30'd0, bank_irq}, 32'h1);
    check("R9", "direct pin1", {24'd0, direct_irq}, 32'h02);
    // R6 write-1 clear
    wr(8'h20, 32'h0);
    rd(8'h20, v); check("R6", "zero write keeps status", v, 32'h0000_0002);
    wr(8'h20, 32'h0000_0002);
    rd(8'h20, v); check("R6", "one write clears status", v, 32'h0);
    // R5 both edges armed on pin 1: falling also sets
    pins(32'h0000_0001, 2);
    rd(8'h20, v); check("R5", "fall on dual-armed pin", v, 32'h0000_0002);
    // R8 upper bank via pin 16 falling
    pins(32'h0001_0001, 2);
    pins(32'h0000_0001, 2);
    rd(8'h20, v); check("R5", "fall on pin16", v, 32'h0001_0002);
    check("R8", "both bank lines", {30'd0, bank_irq}, 32'h3);
    // R7 same-cycle edge and clear on bit 1 (already set)
    @(negedge clk);
    pin_lvl = 32'h0000_0003;
    bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h0000_0002;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    rd(8'h20, v); check("R7", "edge beats clear", v, 32'h0001_0002);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R7", "later clear alone", v, 32'h0);
    // R9 direct line ignores bank gating
    pins(32'h0000_0001, 2);
    wr(8'h08, 32'h0);
    rd(8'h08, v); check("R8", "bank enable readback", v, 32'h0);
    check("R8", "gated bank lines", {30'd0, bank_irq}, 32'h0);
    check("R9", "direct stays with bank off", {24'd0, direct_irq}, 32'h02);
    // Random mix, judged by the every-clock model comparison
    for (int k = 0; k < 3000; k++) begin
      int sel;
      @(negedge clk);
      pin_lvl = pin_lvl ^ ($urandom() & $urandom());
      sel = $urandom_range(0, 7);
      bus_wr = (sel < 6);
      case (sel)
        0: bus_addr = 8'h08;
        1: bus_addr = 8'h10;
        2: bus_addr = 8'h14;
        3: bus_addr = 8'h18;
        4: bus_addr = 8'h1C;
        default: bus_addr = 8'h20;
      endcase
      bus_wdata = $urandom() & $urandom();
    end
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule